// File: doc/BRIEF.md
# Gate Driver Protection Controller

This clocked controller sits between a logic-level drive command and the push-pull output stage of an isolated power-switch gate driver. It turns the command into separate enables: one for the pull-up device, one for a strong pull-down, one for a weak pull-down and one for an active low-state clamp. The design guarantees that the pull-up is never enabled together with a pull-down. The supply monitor, the desaturation comparator and the gate-level comparator all sit outside the block. They reach it as single-bit flags.

In normal operation a rising command edge turns the gate on. A short blanking window follows, during which the desaturation flag is ignored, and the gate stays on until the command falls. If desaturation is seen while the gate is on, the controller drops the pull-up and pulls the gate down through the weak device for a fixed soft-off interval. It switches to the strong device and the clamp as soon as the gate is reported below 2 V. It then holds a mute interval in which the command is ignored and the active-low fault flag is driven. After the mute it recovers by itself, and it waits for a fresh command edge before driving again.

An undervoltage lockout with hysteresis overrides every other function. It keeps the gate pulled low until the supply has crossed the upper threshold, and it forces the gate low again if the supply drops below the lower threshold. The blanking, soft-off and mute lengths are parameters counted in clock cycles.

Top module: `gate_protect_ctrl`

## Requirements
- R1: In every cycle, pullUpEn is 0 whenever strongDnEn or weakDnEn is 1.
- R2: With the supply accepted and no fault pending, a low-to-high change of cmdIn seen at a clock edge sets pullUpEn from that edge on. A 0 on cmdIn seen at a later edge, while the gate is on, clears pullUpEn and sets strongDnEn from that edge. A 1 on cmdIn that arrives while the gate is low and is not a fresh edge does nothing.
- R3: An internal supply-accepted bit is 0 after reset. It becomes 1 at an edge where supRiseOk is 1. It becomes 0 at an edge where supFallOk is 0, and it is unaffected by supRiseOk falling alone. While this bit is 0, the controller enters lockout at the following edge. In lockout, strongDnEn is 1, pullUpEn and weakDnEn are 0, and faultN is 1, whatever the other inputs do. When lockout ends, the gate is low.
- R4: Turn-on needs a fresh command edge. If cmdIn is held high across the end of lockout or the end of a mute, the gate stays low until cmdIn has been seen at 0 and then at 1.
- R5: For BLANK_CYC cycles after a turn-on edge, and at the edge that closes that window, desatIn is ignored. If cmdIn returns to 0 inside the window, the gate turns off normally.
- R6: Once the blanking window has passed, a 1 on desatIn at an edge while the gate is on starts a fault at that edge. pullUpEn becomes 0 and faultN becomes 0. In the soft-off phase weakDnEn equals NOT gateLowIn.
- R7: In the soft-off phase, strongDnEn and clampEn both equal gateLowIn.
- R8: The soft-off phase lasts SOFT_CYC cycles. It is followed by a mute of MUTE_CYC cycles in which strongDnEn is 1 and clampEn equals gateLowIn. faultN stays 0 through both phases, and cmdIn is ignored.
- R9: When the mute ends, faultN returns to 1 at that edge and the gate is in its low state.
- R10: Outside the fault phases, clampEn is 1 only when gateLowIn is 1, cmdIn is 0 and the gate is in its low state. clampEn is therefore 0 whenever pullUpEn is 1.
- R11: While rstN is 0, the outputs are in the lockout state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cmdIn | input | 1 | Drive command, 1 asks for gate on |
| supRiseOk | input | 1 | Supply is above the upper lockout threshold |
| supFallOk | input | 1 | Supply is above the lower lockout threshold |
| desatIn | input | 1 | Desaturation comparator flag |
| gateLowIn | input | 1 | Gate voltage is below 2 V |
| pullUpEn | output | 1 | Enable for the pull-up device |
| strongDnEn | output | 1 | Enable for the strong pull-down device |
| weakDnEn | output | 1 | Enable for the weak soft-off pull-down |
| clampEn | output | 1 | Enable for the active low-state clamp |
| faultN | output | 1 | Active-low desaturation fault flag |

## Verification
The bench goes after several corner cases, each of which exposes a distinct bug.

- A command held high across the end of lockout and across the end of a mute: a design that turns on from the command level would re-drive into the fault.
- A desaturation pulse inside the blanking window: a design that ignores blanking would trip on every turn-on.
- Command toggles during the mute: a design that lets them through would re-enable the pull-up during soft shutdown.
- A supply sitting between the two thresholds, both before and after acceptance: a design without hysteresis would either unlock early or chatter.
- Lockout arriving in the middle of a fault sequence: this must override the sequence.
- The gate-low flag asserted both before and after the soft-off switch: this catches a clamp that engages while the command asks for turn-on.

// File: rtl/gpc_pkg.sv
package gpc_pkg;

  typedef enum logic [2:0] {
    IDLE_LOW = 3'd0,
    BLANK    = 3'd1,
    ON       = 3'd2,
    SOFT_OFF = 3'd3,
    MUTE     = 3'd4,
    UVLO     = 3'd5
  } drvState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadBlank;
    logic loadSoft;
    logic loadMute;
  } ctrlStrobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic supOk;
    logic cmdRise;
    logic timerZero;
  } dpStatus_t;

endpackage

// File: rtl/gpc_datapath.sv
module gpc_datapath
  import gpc_pkg::*;
#(
  parameter int BLANK_CYC = 650,
  parameter int SOFT_CYC  = 1000,
  parameter int MUTE_CYC  = 5000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdIn,
  input  logic        supRiseOk,
  input  logic        supFallOk,
  input  ctrlStrobe_t strobe,
  output dpStatus_t   status
);

  localparam int MAX_BS  = (BLANK_CYC > SOFT_CYC) ? BLANK_CYC : SOFT_CYC;
  localparam int MAX_CYC = (MAX_BS > MUTE_CYC) ? MAX_BS : MUTE_CYC;
  localparam int TMR_W   = $clog2(MAX_CYC + 1);

  logic             supOk;
  logic             cmdPrev;
  logic [TMR_W-1:0] timer;
  logic [TMR_W-1:0] loadVal;
  logic             loadAny;

  // supply acceptance with hysteresis
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      supOk <= 1'b0;
    end else if (!supOk && supRiseOk) begin
      supOk <= 1'b1;
    end else if (supOk && !supFallOk) begin
      supOk <= 1'b0;
    end
  end

  // command history for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdPrev <= 1'b0;
    end else begin
      cmdPrev <= cmdIn;
    end
  end

  // phase length selection
  always_comb begin
    loadAny = strobe.loadBlank | strobe.loadSoft | strobe.loadMute;
    loadVal = '0;
    if (strobe.loadBlank) begin
      loadVal = TMR_W'(BLANK_CYC - 1);
    end else if (strobe.loadSoft) begin
      loadVal = TMR_W'(SOFT_CYC - 1);
    end else if (strobe.loadMute) begin
      loadVal = TMR_W'(MUTE_CYC - 1);
    end
  end

  // shared down-counter for all timed phases
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer <= '0;
    end else if (loadAny) begin
      timer <= loadVal;
    end else if (timer != '0) begin
      timer <= timer - 1'b1;
    end
  end

  assign status.supOk     = supOk;
  assign status.cmdRise   = cmdIn & ~cmdPrev;
  assign status.timerZero = (timer == '0);

endmodule

// File: rtl/gpc_control.sv
module gpc_control
  import gpc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdIn,
  input  logic        desatIn,
  input  logic        gateLowIn,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        pullUpEn,
  output logic        strongDnEn,
  output logic        weakDnEn,
  output logic        clampEn,
  output logic        faultN
);

  drvState_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= UVLO;
    end else begin
      state <= stateNext;
    end
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    if (!status.supOk) begin
      stateNext = UVLO;
    end else begin
      unique case (state)
        UVLO: stateNext = IDLE_LOW;
        IDLE_LOW: begin
          if (status.cmdRise) begin
            stateNext        = BLANK;
            strobe.loadBlank = 1'b1;
          end
        end
        BLANK: begin
          if (!cmdIn) begin
            stateNext = IDLE_LOW;
          end else if (status.timerZero) begin
            stateNext = ON;
          end
        end
        ON: begin
          if (desatIn) begin
            stateNext       = SOFT_OFF;
            strobe.loadSoft = 1'b1;
          end else if (!cmdIn) begin
            stateNext = IDLE_LOW;
          end
        end
        SOFT_OFF: begin
          if (status.timerZero) begin
            stateNext       = MUTE;
            strobe.loadMute = 1'b1;
          end
        end
        MUTE: begin
          if (status.timerZero) begin
            stateNext = IDLE_LOW;
          end
        end
        default: stateNext = UVLO;
      endcase
    end
  end

  // output stage decode
  always_comb begin
    pullUpEn   = 1'b0;
    strongDnEn = 1'b0;
    weakDnEn   = 1'b0;
    clampEn    = 1'b0;
    faultN     = 1'b1;
    unique case (state)
      BLANK, ON: pullUpEn = 1'b1;
      SOFT_OFF: begin
        faultN     = 1'b0;
        weakDnEn   = ~gateLowIn;
        strongDnEn = gateLowIn;
        clampEn    = gateLowIn;
      end
      MUTE: begin
        faultN     = 1'b0;
        strongDnEn = 1'b1;
        clampEn    = gateLowIn;
      end
      default: begin
        strongDnEn = 1'b1;
        clampEn    = gateLowIn & ~cmdIn;
      end
    endcase
  end

endmodule

// File: rtl/gate_protect_ctrl.sv
module gate_protect_ctrl
  import gpc_pkg::*;
#(
  parameter int BLANK_CYC = 650,
  parameter int SOFT_CYC  = 1000,
  parameter int MUTE_CYC  = 5000
) (
  input  logic clk,
  input  logic rstN,
  input  logic cmdIn,
  input  logic supRiseOk,
  input  logic supFallOk,
  input  logic desatIn,
  input  logic gateLowIn,
  output logic pullUpEn,
  output logic strongDnEn,
  output logic weakDnEn,
  output logic clampEn,
  output logic faultN
);

  ctrlStrobe_t strobe;
  dpStatus_t   status;

  gpc_datapath #(
    .BLANK_CYC(BLANK_CYC),
    .SOFT_CYC (SOFT_CYC),
    .MUTE_CYC (MUTE_CYC)
  ) uDatapath (
    .clk      (clk),
    .rstN     (rstN),
    .cmdIn    (cmdIn),
    .supRiseOk(supRiseOk),
    .supFallOk(supFallOk),
    .strobe   (strobe),
    .status   (status)
  );

  gpc_control uControl (
    .clk       (clk),
    .rstN      (rstN),
    .cmdIn     (cmdIn),
    .desatIn   (desatIn),
    .gateLowIn (gateLowIn),
    .status    (status),
    .strobe    (strobe),
    .pullUpEn  (pullUpEn),
    .strongDnEn(strongDnEn),
    .weakDnEn  (weakDnEn),
    .clampEn   (clampEn),
    .faultN    (faultN)
  );

endmodule

// File: rtl/gpc_checker.sv
module gpc_checker (
  input logic clk,
  input logic rstN,
  input logic cmdIn,
  input logic supFallOk,
  input logic desatIn,
  input logic pullUpEn,
  input logic strongDnEn,
  input logic weakDnEn,
  input logic clampEn,
  input logic faultN
);

  AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (!rstN)
    !(pullUpEn && (strongDnEn || weakDnEn))); // R1

  AST_TURN_ON_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pullUpEn) |-> ($past(cmdIn) && !$past(cmdIn, 2))); // R4

  AST_LOCKOUT_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !supFallOk |=> ##1 (!pullUpEn && strongDnEn && faultN)); // R3

  AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(faultN) |-> $past(pullUpEn && desatIn)); // R6

  AST_WEAK_IN_FAULT: assert property (@(posedge clk) disable iff (!rstN)
    weakDnEn |-> !faultN); // R6

  AST_CLAMP_OFF_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    pullUpEn |-> !clampEn); // R10

endmodule

bind gate_protect_ctrl gpc_checker uChecker (
  .clk       (clk),
  .rstN      (rstN),
  .cmdIn     (cmdIn),
  .supFallOk (supFallOk),
  .desatIn   (desatIn),
  .pullUpEn  (pullUpEn),
  .strongDnEn(strongDnEn),
  .weakDnEn  (weakDnEn),
  .clampEn   (clampEn),
  .faultN    (faultN)
);

// File: tb/gate_protect_ctrl_test.sv
module gate_protect_ctrl_test;

  localparam int BLANK_LEN = 5;
  localparam int SOFT_LEN  = 4;
  localparam int MUTE_LEN  = 12;

  // model modes
  localparam int M_LOW = 0, M_BLANK = 1, M_ON = 2, M_SOFT = 3, M_MUTE = 4, M_LOCK = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdIn = 1'b1, supRiseOk = 1'b0, supFallOk = 1'b0, desatIn = 1'b0, gateLowIn = 1'b0;
  logic pullUpEn, strongDnEn, weakDnEn, clampEn, faultN;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  bit done = 1'b0;
  string curReq = "R11";

  int mMode = M_LOCK;
  int mElapsed = 0;
  bit mSup = 1'b0;
  bit mPrev = 1'b0;

  gate_protect_ctrl #(
    .BLANK_CYC(BLANK_LEN), .SOFT_CYC(SOFT_LEN), .MUTE_CYC(MUTE_LEN)
  ) uut (
    .clk(clk), .rstN(rstN), .cmdIn(cmdIn), .supRiseOk(supRiseOk),
    .supFallOk(supFallOk), .desatIn(desatIn), .gateLowIn(gateLowIn),
    .pullUpEn(pullUpEn), .strongDnEn(strongDnEn), .weakDnEn(weakDnEn),
    .clampEn(clampEn), .faultN(faultN)
  );

  always #2 clk = ~clk;

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    int nxt;
    bit rise;
    if (!rstN) begin
      mMode = M_LOCK; mElapsed = 0; mSup = 0; mPrev = 0;
    end else begin
      rise = cmdIn && !mPrev;
      nxt = mMode;
      if (!mSup) nxt = M_LOCK;
      else if (mMode == M_LOCK) nxt = M_LOW;
      else if (mMode == M_LOW) begin
        if (rise) nxt = M_BLANK;
      end else if (mMode == M_BLANK) begin
        if (!cmdIn) nxt = M_LOW;
        else if (mElapsed == BLANK_LEN - 1) nxt = M_ON;
      end else if (mMode == M_ON) begin
        if (desatIn) nxt = M_SOFT;
        else if (!cmdIn) nxt = M_LOW;
      end else if (mMode == M_SOFT) begin
        if (mElapsed == SOFT_LEN - 1) nxt = M_MUTE;
      end else if (mMode == M_MUTE) begin
        if (mElapsed == MUTE_LEN - 1) nxt = M_LOW;
      end
      if (nxt != mMode) mElapsed = 0;
      else mElapsed = mElapsed + 1;
      mMode = nxt;
      if (!mSup && supRiseOk) mSup = 1;
      else if (mSup && !supFallOk) mSup = 0;
      mPrev = cmdIn;
    end
  end

  task automatic checkBit(input string req, input string name, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at cycle %0d", req, name, act, exp, cycles);
    end
  endtask

  // compare against the reference in the middle of every cycle
  always @(negedge clk) begin
    logic ePu, eSd, eWk, eCl, eFn;
    cycles++;
    if (rstN && !done) begin
      ePu = 0; eSd = 0; eWk = 0; eCl = 0; eFn = 1;
      case (mMode)
        M_BLANK, M_ON: ePu = 1;
        M_SOFT: begin eFn = 0; eWk = !gateLowIn; eSd = gateLowIn; eCl = gateLowIn; end
        M_MUTE: begin eFn = 0; eSd = 1; eCl = gateLowIn; end
        default: begin eSd = 1; eCl = gateLowIn && !cmdIn; end
      endcase
      checkBit(curReq, "pullUpEn", pullUpEn, ePu);
      checkBit(curReq, "strongDnEn", strongDnEn, eSd);
      checkBit(curReq, "weakDnEn", weakDnEn, eWk);
      checkBit(curReq, "clampEn", clampEn, eCl);
      checkBit(curReq, "faultN", faultN, eFn);
      checkBit("R1", "shootThrough", pullUpEn && (strongDnEn || weakDnEn), 1'b0);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    cyc(3);
    @(negedge clk);
    checkBit("R11", "pullUpEn", pullUpEn, 1'b0);
    checkBit("R11", "strongDnEn", strongDnEn, 1'b1);
    checkBit("R11", "weakDnEn", weakDnEn, 1'b0);
    checkBit("R11", "faultN", faultN, 1'b1);
    cyc(1);
    rstN = 1'b1;
    // supply between thresholds before acceptance stays locked
    curReq = "R3";
    supFallOk = 1; cyc(6);
    supRiseOk = 1; cyc(2);
    supRiseOk = 0; cyc(4);
    // command held high across lockout exit must not drive
    curReq = "R4"; cyc(4);
    // normal drive, blanking
    curReq = "R2"; cmdIn = 0; cyc(2);
    cmdIn = 1; cyc(2);
    curReq = "R5"; desatIn = 1; cyc(3);
    desatIn = 0; cyc(6);
    curReq = "R10"; gateLowIn = 1; cyc(2);
    cmdIn = 0; cyc(3);
    gateLowIn = 0;
    curReq = "R2"; cmdIn = 1; cyc(1);
    cmdIn = 0; cyc(3);
    // fault sequence
    curReq = "R6"; cmdIn = 1; cyc(8);
    desatIn = 1; cyc(1);
    desatIn = 0;
    curReq = "R7"; cyc(2);
    gateLowIn = 1; cyc(3);
    curReq = "R8"; cmdIn = 0; cyc(2);
    cmdIn = 1; cyc(2);
    cmdIn = 0; cyc(3);
    cmdIn = 1; cyc(8);
    curReq = "R9"; cyc(6);
    curReq = "R4"; cmdIn = 0; cyc(1);
    cmdIn = 1; gateLowIn = 0; cyc(8);
    // lockout while driving
    curReq = "R3"; supFallOk = 0; cyc(4);
    supFallOk = 1; supRiseOk = 1; cyc(2);
    supRiseOk = 0; cmdIn = 0; cyc(2);
    cmdIn = 1; cyc(8);
    curReq = "R6"; desatIn = 1; cyc(1);
    desatIn = 0; cyc(2);
    // lockout in the middle of a fault
    curReq = "R3"; supFallOk = 0; cyc(3);
    supFallOk = 1; supRiseOk = 1; cyc(3);
    supRiseOk = 0; cyc(4);
    curReq = "R10"; gateLowIn = 1; cmdIn = 0; cyc(20);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog run did not complete actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule